// File: doc/BRIEF.md
# Set/Clear Mailbox Bank with Per-Core Interrupt Routing

This block is a bank of sixteen 32-bit mailboxes for inter-core signalling. Each of four cores owns four of them. A sender posts bits into a mailbox by writing to that mailbox's set address. The write data is ORed into the mailbox, so several senders can post independent flags without a read-modify-write. The receiver writes ones to the matching clear address to acknowledge individual bits. A read at the clear address returns the current contents.

A mailbox holding any non-zero value counts as pending. A per-core routing byte decides how each pending mailbox is delivered. Its upper nibble selects fast-interrupt (FIQ) class and its lower nibble selects normal-interrupt (IRQ) class. When both are set, FIQ wins. A pending mailbox with neither bit set raises no request. Each core gets one IRQ line and one FIQ line. The raw per-mailbox pending vector and the per-mailbox FIQ class are also brought out.

The register interface is one 32-bit word port with an 8-bit byte address. Only full-word, word-aligned accesses take effect. Read data is registered and appears on the cycle after the read strobe.

Top module: `mbx_bank`

## Requirements
- R1: A word write at byte address 0x80 + 4*i (i = core*4 + j, 0..15) ORs the write data into mailbox i. The other mailboxes are unchanged.
- R2: A word write at byte address 0xC0 + 4*i clears each bit of mailbox i whose write-data bit is 1. All other bits are kept.
- R3: A word read at 0xC0 + 4*i returns mailbox i on rdData one cycle after the read strobe. A read anywhere in 0x80..0xBF returns zero.
- R4: A word write at 0x50 + 4*c (c = 0..3) stores the low 8 bits of the data as the routing byte of core c. A read at that address returns the byte zero-extended to 32 bits.
- R5: mbxPending bit core*4+j is 1 exactly when mailbox core*4+j is non-zero.
- R6: For a pending mailbox j of core c, routing bit j+4 makes it FIQ class (mbxClassFiq bit set). Otherwise routing bit j makes it IRQ class. With neither bit set it is masked. mbxClassFiq is 0 for a mailbox that is not pending.
- R7: coreIrq[c] is 1 exactly when at least one mailbox of core c is IRQ class. coreFiq[c] is 1 exactly when at least one is FIQ class.
- R8: Reset clears all sixteen mailboxes and all four routing bytes, so every output is zero after reset.
- R9: An access with accWord low, or with addr[1:0] not zero, changes no state, and such a read returns zero.
- R10: Pending, class and interrupt outputs change on the clock edge that takes the write that changes them. They do not change earlier.
- R11: A write to any address outside the routing, set and clear windows changes no state. A read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| accWord | input | 1 | Access is a full 32-bit word |
| addr | input | 8 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| mbxPending | output | 16 | Per-mailbox non-zero flag, bit core*4+j |
| mbxClassFiq | output | 16 | Per-mailbox FIQ-class flag, bit core*4+j |
| coreIrq | output | 4 | Per-core IRQ request |
| coreFiq | output | 4 | Per-core FIQ request |

## Verification
The bench sweeps all 256 routing bytes for every core. In each sweep one mailbox of that core is empty, so two kinds of bug show up. A design that lets IRQ win over FIQ, or that routes an empty mailbox, gives the wrong class or a wrong core line. A design that decodes the routing nibbles against the wrong mailbox also gives a wrong class or a wrong core line. Set and clear writes are applied to every mailbox with overlapping bit patterns. Dropping the OR would lose earlier bits, and clearing on zeros instead of ones would wipe the wrong bits. The bench also sends sub-word, misaligned and out-of-window accesses, and reads the set window. An address decoder that is too loose would corrupt a mailbox or return non-zero data. Finally, outputs are sampled just before the writing edge, so a combinational path from the write port to the pending flags is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_CORES    = 4;
  localparam int MBX_PER_CORE = 4;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 8;

  localparam int NUM_MBX = NUM_CORES * MBX_PER_CORE;
  localparam int IDX_W   = $clog2(NUM_MBX);
  localparam int CORE_W  = $clog2(NUM_CORES);
  localparam int CTL_W   = 2 * MBX_PER_CORE;
  localparam int WORD_B  = DATA_W / 8;

  // byte offsets of the three windows
  localparam int CTL_BASE = 'h50;
  localparam int SET_BASE = 'h80;
  localparam int CLR_BASE = 'hC0;
  localparam int CTL_SPAN = NUM_CORES * WORD_B;
  localparam int MBX_SPAN = NUM_MBX * WORD_B;

  typedef struct packed {
    logic              setWr;
    logic              clrWr;
    logic              ctlWr;
    logic              rdMbx;
    logic              rdCtl;
    logic              rdAny;
    logic [IDX_W-1:0]  mbxIdx;
    logic [CORE_W-1:0] coreIdx;
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              accWord,
  input  logic [ADDR_W-1:0] addr,
  output mbx_strobe_t       strb
);
  localparam int LSB_W = $clog2(WORD_B);

  logic wordOk;
  logic inCtl, inSet, inClr;
  int   addrInt;
  logic [ADDR_W-1:0] setOff, clrOff, ctlOff;

  always_comb begin
    addrInt = int'(addr);
    wordOk  = accWord && (addr[LSB_W-1:0] == '0);
    inCtl   = (addrInt >= CTL_BASE) && (addrInt < CTL_BASE + CTL_SPAN);
    inSet   = (addrInt >= SET_BASE) && (addrInt < SET_BASE + MBX_SPAN);
    inClr   = (addrInt >= CLR_BASE) && (addrInt < CLR_BASE + MBX_SPAN);
    setOff  = addr - ADDR_W'(SET_BASE);
    clrOff  = addr - ADDR_W'(CLR_BASE);
    ctlOff  = addr - ADDR_W'(CTL_BASE);
  end

  always_comb begin
    strb         = '0;
    strb.setWr   = wrEn && wordOk && inSet;
    strb.clrWr   = wrEn && wordOk && inClr;
    strb.ctlWr   = wrEn && wordOk && inCtl;
    strb.rdMbx   = rdEn && wordOk && inClr;
    strb.rdCtl   = rdEn && wordOk && inCtl;
    strb.rdAny   = rdEn;
    strb.mbxIdx  = inSet ? IDX_W'(setOff >> LSB_W) : IDX_W'(clrOff >> LSB_W);
    strb.coreIdx = CORE_W'(ctlOff >> LSB_W);
  end
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mbx_strobe_t          strb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_MBX-1:0]   mbxPending,
  output logic [NUM_MBX-1:0]   mbxClassFiq,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES-1:0] coreFiq
);
  logic [DATA_W-1:0] mbxWord [NUM_MBX];
  logic [CTL_W-1:0]  ctlByte [NUM_CORES];
  logic [NUM_MBX-1:0] mbxIrqCls;

  // mailbox storage: set window ORs in, clear window knocks out ones
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
    logic [DATA_W-1:0] mbxQ;
    logic hit;
    assign hit = (strb.mbxIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)                  mbxQ <= '0;
      else if (strb.setWr && hit) mbxQ <= mbxQ | wrData;
      else if (strb.clrWr && hit) mbxQ <= mbxQ & ~wrData;
    end
    assign mbxWord[i]    = mbxQ;
    assign mbxPending[i] = |mbxQ;
  end

  // per-core routing byte and delivery class
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CTL_W-1:0] ctlQ;
    always_ff @(posedge clk) begin
      if (!rstN)                                             ctlQ <= '0;
      else if (strb.ctlWr && strb.coreIdx == CORE_W'(c))     ctlQ <= wrData[CTL_W-1:0];
    end
    assign ctlByte[c] = ctlQ;

    for (genvar j = 0; j < MBX_PER_CORE; j++) begin : g_slot
      localparam int K = c * MBX_PER_CORE + j;
      logic fiqEn, irqEn;
      assign fiqEn = ctlQ[j + MBX_PER_CORE];
      assign irqEn = ctlQ[j];
      assign mbxClassFiq[K] = mbxPending[K] && fiqEn;
      assign mbxIrqCls[K]   = mbxPending[K] && irqEn && !fiqEn;
    end

    assign coreFiq[c] = |mbxClassFiq[c*MBX_PER_CORE +: MBX_PER_CORE];
    assign coreIrq[c] = |mbxIrqCls[c*MBX_PER_CORE +: MBX_PER_CORE];
  end

  // registered read port
  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (strb.rdMbx)      rdNext = mbxWord[strb.mbxIdx];
    else if (strb.rdCtl) rdNext = DATA_W'(ctlByte[strb.coreIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdAny) rdData <= rdNext;
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 accWord,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_MBX-1:0]   mbxPending,
  output logic [NUM_MBX-1:0]   mbxClassFiq,
  output logic [NUM_CORES-1:0] coreIrq,
  output logic [NUM_CORES-1:0] coreFiq
);
  mbx_strobe_t strb;

  mbx_ctrl u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .accWord (accWord),
    .addr    (addr),
    .strb    (strb)
  );

  mbx_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .rdData      (rdData),
    .mbxPending  (mbxPending),
    .mbxClassFiq (mbxClassFiq),
    .coreIrq     (coreIrq),
    .coreFiq     (coreFiq)
  );
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk
  import mbx_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic                 accWord,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_MBX-1:0]   mbxPending,
  input logic [NUM_MBX-1:0]   mbxClassFiq,
  input logic [NUM_CORES-1:0] coreIrq,
  input logic [NUM_CORES-1:0] coreFiq
);
  logic aligned, setWin, clrWin;
  assign aligned = accWord && (addr[1:0] == 2'b00);
  assign setWin  = aligned && (int'(addr) >= SET_BASE) && (int'(addr) < SET_BASE + MBX_SPAN);
  assign clrWin  = aligned && (int'(addr) >= CLR_BASE) && (int'(addr) < CLR_BASE + MBX_SPAN);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (mbxPending == '0 && coreIrq == '0 && coreFiq == '0 && rdData == '0)); // R8

  AST_SET_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && setWin) |=> (($past(mbxPending) & ~mbxPending) == '0)); // R1

  AST_CLR_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && clrWin) |=> ((mbxPending & ~$past(mbxPending)) == '0)); // R2

  AST_SETWIN_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && setWin) |=> (rdData == '0)); // R3

  AST_FIQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    ((mbxClassFiq & ~mbxPending) == '0)); // R6

  AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    ((coreIrq | coreFiq) != '0) |-> (mbxPending != '0)); // R7

  AST_SUBWORD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !accWord) |=> $stable(mbxPending)); // R9

  AST_SUBWORD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !accWord) |=> (rdData == '0)); // R9
endmodule

bind mbx_bank mbx_bank_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .accWord     (accWord),
  .addr        (addr),
  .rdData      (rdData),
  .mbxPending  (mbxPending),
  .mbxClassFiq (mbxClassFiq),
  .coreIrq     (coreIrq),
  .coreFiq     (coreFiq)
);

// File: tb/sim_mbx_bank.sv
`timescale 1ns/1ps
module sim_mbx_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        accWord = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] mbxPending, mbxClassFiq;
  logic [3:0]  coreIrq, coreFiq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] expMbx [16];
  logic [7:0]  expCtl [4];

  always #4 clk = ~clk;

  mbx_bank u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // spec model of a register write
  task automatic modelWr(logic [7:0] a, logic [31:0] d, bit word);
    int ai = int'(a);
    if (!word || a[1:0] != 2'b00) return;
    if (ai >= 'h80 && ai < 'hC0)      expMbx[(ai - 'h80) / 4] |= d;
    else if (ai >= 'hC0)              expMbx[(ai - 'hC0) / 4] &= ~d;
    else if (ai >= 'h50 && ai < 'h60) expCtl[(ai - 'h50) / 4] = d[7:0];
  endtask

  function automatic logic [31:0] modelRd(logic [7:0] a, bit word);
    int ai = int'(a);
    if (!word || a[1:0] != 2'b00) return 32'h0;
    if (ai >= 'hC0)              return expMbx[(ai - 'hC0) / 4];
    if (ai >= 'h50 && ai < 'h60) return {24'h0, expCtl[(ai - 'h50) / 4]};
    return 32'h0;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d, bit word = 1'b1);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; accWord = word;
    @(posedge clk); #1;
    wrEn = 1'b0; accWord = 1'b1;
    modelWr(a, d, word);
  endtask

  task automatic rd(logic [7:0] a, bit word, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a; accWord = word;
    @(posedge clk); #1;
    rdEn = 1'b0; accWord = 1'b1;
    @(negedge clk);
    d = rdData;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, bit word = 1'b1);
    logic [31:0] d;
    rd(a, word, d);
    chk($sformatf("%s read @%h", tag, a), d, modelRd(a, word));
  endtask

  task automatic chkOut(string ctx);
    logic [15:0] p, f;
    logic [3:0]  ir, fq;
    p = '0; f = '0; ir = '0; fq = '0;
    for (int i = 0; i < 16; i++) begin
      int c = i / 4;
      int j = i % 4;
      bit pend = (expMbx[i] != 0);
      bit fsel = expCtl[c][j + 4];
      bit isel = expCtl[c][j];
      p[i] = pend;
      f[i] = pend && fsel;
      if (pend && fsel)               fq[c] = 1'b1;
      else if (pend && isel)          ir[c] = 1'b1;
    end
    @(negedge clk);
    chk({"R5 pending ", ctx}, 32'(mbxPending), 32'(p));
    chk({"R6 class ", ctx}, 32'(mbxClassFiq), 32'(f));
    chk({"R7 irq ", ctx}, 32'(coreIrq), 32'(ir));
    chk({"R7 fiq ", ctx}, 32'(coreFiq), 32'(fq));
  endtask

  task automatic clearAll();
    for (int i = 0; i < 16; i++) wr(8'(8'hC0 + 4*i), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) expMbx[i] = '0;
    for (int c = 0; c < 4; c++)  expCtl[c] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R8: reset state
    chkOut("R8 after reset");
    for (int i = 0; i < 16; i++) rdChk("R8 mailbox", 8'(8'hC0 + 4*i));
    for (int c = 0; c < 4; c++)  rdChk("R8 routing", 8'(8'h50 + 4*c));

    // R1: set accumulates, neighbours untouched
    for (int i = 0; i < 16; i++) wr(8'(8'h80 + 4*i), 32'(1) << i);
    for (int i = 0; i < 16; i++) wr(8'(8'h80 + 4*i), 32'h5A00_0000 ^ (32'(i) << 20));
    for (int i = 0; i < 16; i++) rdChk("R1 set-or", 8'(8'hC0 + 4*i));
    chkOut("R6 masked routing");

    // R3: set window reads zero
    for (int i = 0; i < 16; i += 5) rdChk("R3 set-window", 8'(8'h80 + 4*i));

    // R2: partial and full clears
    for (int i = 0; i < 16; i++) wr(8'(8'hC0 + 4*i), 32'h0A00_0000 | (32'(1) << i));
    for (int i = 0; i < 16; i++) rdChk("R2 clear-ones", 8'(8'hC0 + 4*i));
    wr(8'hC0 + 8'd12, 32'hFFFF_FFFF);
    rdChk("R2 clear-all", 8'hCC);
    chkOut("R2/R5 cleared mailbox");

    // R4: routing byte keeps low 8 bits
    wr(8'h54, 32'h1234_56F3);
    rdChk("R4 routing", 8'h54);
    wr(8'h54, 32'h0);

    // R6/R7: exhaustive routing sweep per core, mailbox j==c empty
    clearAll();
    for (int i = 0; i < 16; i++)
      if ((i % 4) != (i / 4)) wr(8'(8'h80 + 4*i), 32'(i + 1) << 8);
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 256; v++) begin
        wr(8'(8'h50 + 4*c), {24'hC3A5_96, 8'(v)});
        chkOut($sformatf("R6/R7 core%0d ctl=%02h", c, v));
      end
      rdChk("R4 routing after sweep", 8'(8'h50 + 4*c));
    end

    // R10: no change before the writing edge, change right after it
    clearAll();
    wr(8'h54, 32'h0000_0002);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h94; wrData = 32'h0000_0100; accWord = 1'b1;
    #3;
    chk("R10 pending before edge", 32'(mbxPending[5]), 32'h0);
    chk("R10 irq before edge", 32'(coreIrq[1]), 32'h0);
    @(posedge clk); #1;
    wrEn = 1'b0;
    modelWr(8'h94, 32'h0000_0100, 1'b1);
    chk("R10 pending after edge", 32'(mbxPending[5]), 32'h1);
    chk("R10 irq after edge", 32'(coreIrq[1]), 32'h1);
    chkOut("R10 settled");

    // R9: sub-word and misaligned accesses
    wr(8'h98, 32'hFFFF_0000, 1'b0);
    wr(8'h99, 32'h0000_FFFF);
    wr(8'hD4, 32'hFFFF_FFFF, 1'b0);
    wr(8'h51, 32'h0000_00FF);
    rdChk("R9 sub-word set ignored", 8'hD8);
    rdChk("R9 sub-word clear ignored", 8'hD4);
    rdChk("R9 sub-word read", 8'hD4, 1'b0);
    rdChk("R9 misaligned read", 8'hD5);
    rdChk("R9 routing kept", 8'h50);
    chkOut("R9 no state change");

    // R11: unmapped windows
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) rdChk("R11 mailbox kept", 8'(8'hC0 + 4*i));
    for (int c = 0; c < 4; c++)  rdChk("R11 routing kept", 8'(8'h50 + 4*c));
    rdChk("R11 unmapped read", 8'h60);
    rdChk("R11 unmapped read", 8'h0C);
    chkOut("R11 outputs kept");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule